// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog counter that watches the software after every internal reset. It starts counting when the internal reset is released and advances once every two clock cycles. The count starts from a value set by a reload input. If the software does not service it in time, the counter runs past its top value. The block then raises a one-cycle reset request and stops until the next internal reset ends.

Software has three single-cycle command strobes:
- A service strobe restarts the timeout and clears the cause flag.
- An end-of-initialization strobe closes the disable window.
- A disable strobe switches the watchdog off. It only takes effect while the window that opens at each internal reset is still open.

A cause flag records that the last reset came from the watchdog. It is kept through internal resets, so boot code can read it. Only the power-on reset or a service clears it.

Two reset inputs are used:
- `por_n_i` is the asynchronous power-on (external hardware) reset. It is already synchronized on release.
- `sys_rst_n_i` is the internal reset level. It is driven by the reset sequencer, which also consumes `ovf_o`.

Top module: `wdg_guard`

## Requirements
- R1: While `por_n_i` is low, `ovf_o` and `cause_o` are 0.
- R2: The counter is held while `sys_rst_n_i` is low. Counting starts at the first clock edge with `sys_rst_n_i` high. Call the last edge with `sys_rst_n_i` low (or the last service edge) the load edge L. The timeout is `TO(r) = PRESC * (2**CNT_W - r * 2**(CNT_W-RELOAD_W))` edges, where r is the reload value. `ovf_o` is high right after edge L+TO(r). With the defaults this is 131072 cycles for r = 0.
- R3: The reload value is sampled at the load edge. It forms the upper RELOAD_W bits of the start count, and the lower bits start at zero.
- R4: `ovf_o` is high for exactly one cycle. After it, no further `ovf_o` occurs until `sys_rst_n_i` has been low again.
- R5: A service strobe (`svc_i` high at an edge while `sys_rst_n_i` is high) reloads the counter. That edge becomes the new L. A service after an overflow does not restart counting.
- R6: `cause_o` becomes 1 in the same cycle as `ovf_o`. It keeps its value while `sys_rst_n_i` is low.
- R7: `cause_o` is cleared by a service strobe or by `por_n_i` low, and by nothing else.
- R8: A disable strobe is accepted at an edge while the window is open, including an edge where a service or end-of-initialization strobe closes it. Once accepted, no `ovf_o` occurs until the next internal reset.
- R9: A service or end-of-initialization strobe closes the window. A later disable strobe has no effect, and the overflow comes at its normal time.
- R10: Each internal reset reopens the window and cancels an earlier disable.
- R11: All strobes are ignored while `sys_rst_n_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| por_n_i | input | 1 | power-on reset, active low, asynchronous assert |
| sys_rst_n_i | input | 1 | internal reset level, active low |
| svc_i | input | 1 | service strobe |
| dis_i | input | 1 | disable strobe |
| einit_i | input | 1 | end-of-initialization strobe |
| reload_i | input | RELOAD_W | reload value, upper bits of the start count |
| ovf_o | output | 1 | one-cycle reset request on overflow |
| cause_o | output | 1 | watchdog-caused reset flag |

## Verification
The bench sweeps every reload value in a narrow configuration and measures the overflow edge exactly. An off-by-one in the prescaler, or a wrong placement of the reload bits, shows up as a timeout a few edges off.

Several cases target the disable window:
- A disable after a service or after end-of-initialization must be ignored. A design whose window never closes would then miss its overflow.
- A disable after an internal reset that follows a disabled run must take effect again. A design whose window does not reopen would overflow instead.
- An internal reset without a disable must time out normally. A design that keeps the disabled state would stay silent.

The cause flag is checked across an internal reset, a service strobed during reset and a power-on reset. A flag cleared by the wrong reset, or by an ignored strobe, fails these checks. A service after an overflow must not restart the count. A design that restarts would produce a second request.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // command strobes sampled at each clock edge
  typedef struct packed {
    logic svc;
    logic dis;
    logic einit;
  } wdg_cmd_t;

  // number of clock edges from a load edge to the overflow edge
  function automatic int unsigned wdg_timeout(input int unsigned cnt_w,
                                              input int unsigned rld_w,
                                              input int unsigned presc,
                                              input int unsigned rld);
    return presc * ((1 << cnt_w) - rld * (1 << (cnt_w - rld_w)));
  endfunction

endpackage

// File: rtl/wdg_presc.sv
module wdg_presc #(
  parameter int unsigned PRESC = 2
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (PRESC <= 1) begin : g_direct
      assign tick_o = run_i & ~clr_i;
    end else begin : g_div
      localparam int unsigned PRE_W = $clog2(PRESC);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESC - 1);

      logic [PRE_W-1:0] pre_q, pre_d;

      always_comb begin
        pre_d = pre_q;
        if (clr_i) begin
          pre_d = '0;
        end else if (run_i) begin
          pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_d;
        end
      end

      assign tick_o = run_i & ~clr_i & (pre_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RELOAD_W = 8
) (
  input  logic                clk_i,
  input  logic                por_n_i,
  input  logic                load_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                tick_i,
  output logic                hit_o,
  output logic                ovf_o
);

  localparam int unsigned LOW_W = CNT_W - RELOAD_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] start_val;
  logic             ovf_q, ovf_d;

  generate
    if (LOW_W == 0) begin : g_full
      assign start_val = reload_i;
    end else begin : g_split
      assign start_val = {reload_i, {LOW_W{1'b0}}};
    end
  endgenerate

  assign hit_o = tick_i & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = start_val;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
    ovf_d = hit_o & ~load_i;
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;

endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
(
  input  logic     clk_i,
  input  logic     por_n_i,
  input  logic     sys_up_i,
  input  wdg_cmd_t cmd_i,
  input  logic     hit_i,
  output logic     load_o,
  output logic     run_o,
  output logic     cause_o
);

  logic win_q,   win_d;
  logic dis_q,   dis_d;
  logic halt_q,  halt_d;
  logic cause_q, cause_d;
  logic svc_ok;

  assign svc_ok = sys_up_i & cmd_i.svc;
  assign load_o = ~sys_up_i | svc_ok;
  assign run_o  = sys_up_i & ~dis_q & ~halt_q;

  always_comb begin
    win_d   = win_q;
    dis_d   = dis_q;
    halt_d  = halt_q;
    cause_d = cause_q;
    if (!sys_up_i) begin
      win_d  = 1'b1;
      dis_d  = 1'b0;
      halt_d = 1'b0;
    end else begin
      if (cmd_i.dis && win_q) begin
        dis_d = 1'b1;
      end
      if (cmd_i.svc || cmd_i.einit) begin
        win_d = 1'b0;
      end
      if (hit_i) begin
        halt_d = 1'b1;
      end
    end
    if (svc_ok) begin
      cause_d = 1'b0;
    end else if (hit_i) begin
      cause_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      win_q   <= 1'b1;
      dis_q   <= 1'b0;
      halt_q  <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      win_q   <= win_d;
      dis_q   <= dis_d;
      halt_q  <= halt_d;
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RELOAD_W = 8,
  parameter int unsigned PRESC    = 2
) (
  input  logic                clk_i,
  input  logic                por_n_i,
  input  logic                sys_rst_n_i,
  input  logic                svc_i,
  input  logic                dis_i,
  input  logic                einit_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                ovf_o,
  output logic                cause_o
);

  wdg_cmd_t cmd;
  logic     load, run, tick, hit;

  assign cmd.svc   = svc_i;
  assign cmd.dis   = dis_i;
  assign cmd.einit = einit_i;

  wdg_ctrl u_ctrl (
    .clk_i    (clk_i),
    .por_n_i  (por_n_i),
    .sys_up_i (sys_rst_n_i),
    .cmd_i    (cmd),
    .hit_i    (hit),
    .load_o   (load),
    .run_o    (run),
    .cause_o  (cause_o)
  );

  wdg_presc #(.PRESC(PRESC)) u_presc (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .clr_i   (load),
    .run_i   (run),
    .tick_o  (tick)
  );

  wdg_count #(.CNT_W(CNT_W), .RELOAD_W(RELOAD_W)) u_count (
    .clk_i    (clk_i),
    .por_n_i  (por_n_i),
    .load_i   (load),
    .reload_i (reload_i),
    .tick_i   (tick),
    .hit_o    (hit),
    .ovf_o    (ovf_o)
  );

endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk (
  input logic clk_i,
  input logic por_n_i,
  input logic sys_rst_n_i,
  input logic svc_i,
  input logic ovf_o,
  input logic cause_o
);

  logic fired_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      fired_q <= 1'b0;
    end else if (!sys_rst_n_i) begin
      fired_q <= 1'b0;
    end else if (ovf_o) begin
      fired_q <= 1'b1;
    end
  end

  assert_ovf_pulse_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ovf_o |=> !ovf_o);

  assert_single_ovf_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ovf_o |-> !fired_q);

  assert_ovf_cause_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ovf_o |-> cause_o);

  assert_cause_hold_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !sys_rst_n_i |=> $stable(cause_o));

  assert_svc_clear_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (sys_rst_n_i && svc_i) |=> (!cause_o && !ovf_o));

  assert_held_quiet_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !sys_rst_n_i |=> !ovf_o);

endmodule

bind wdg_guard wdg_guard_chk u_chk (
  .clk_i       (clk_i),
  .por_n_i     (por_n_i),
  .sys_rst_n_i (sys_rst_n_i),
  .svc_i       (svc_i),
  .ovf_o       (ovf_o),
  .cause_o     (cause_o)
);

// File: tb/wdg_guard_bench.sv
`timescale 1ns/1ps
module wdg_guard_bench;
  import wdg_pkg::*;

  localparam int unsigned CNT_W    = 8;
  localparam int unsigned RELOAD_W = 4;
  localparam int unsigned PRESC    = 2;
  localparam int          WAIT     = 600;

  logic                clk = 1'b0;
  logic                por_n = 1'b0;
  logic                sys_n = 1'b0;
  logic                svc = 1'b0;
  logic                dis = 1'b0;
  logic                einit = 1'b0;
  logic [RELOAD_W-1:0] rld = '0;
  logic                ovf, cause;

  int tests = 0;
  int fails = 0;
  int since = 0;
  int n_ovf = 0;
  int ovf_at = -1;

  always #10 clk = ~clk;

  wdg_guard #(.CNT_W(CNT_W), .RELOAD_W(RELOAD_W), .PRESC(PRESC)) u_wdg_guard (
    .clk_i       (clk),
    .por_n_i     (por_n),
    .sys_rst_n_i (sys_n),
    .svc_i       (svc),
    .dis_i       (dis),
    .einit_i     (einit),
    .reload_i    (rld),
    .ovf_o       (ovf),
    .cause_o     (cause)
  );

  function automatic int to_of(input int r);
    return PRESC * ((1 << CNT_W) - r * (1 << (CNT_W - RELOAD_W)));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    since++;
    @(negedge clk);
    if (ovf) begin
      n_ovf++;
      ovf_at = since;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic clear_obs();
    since = 0; n_ovf = 0; ovf_at = -1;
  endtask

  task automatic irst(input int r);
    rld = RELOAD_W'(r);
    sys_n = 1'b0;
    cyc();
    sys_n = 1'b1;
    clear_obs();
  endtask

  task automatic service(input int r);
    rld = RELOAD_W'(r);
    svc = 1'b1;
    cyc();
    svc = 1'b0;
    clear_obs();
  endtask

  task automatic pulse_dis();
    dis = 1'b1; cyc(); dis = 1'b0;
  endtask

  task automatic pulse_einit();
    einit = 1'b1; cyc(); einit = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!ovf && !cause, "R1 reset state", {ovf, cause}, 0);
    por_n = 1'b1;

    // R2 R3 R4: sweep every reload value
    for (int r = 0; r < (1 << RELOAD_W); r++) begin
      irst(r);
      run(WAIT);
      check(n_ovf == 1 && ovf_at == to_of(r), "R2/R3 timeout", ovf_at, to_of(r));
      check(n_ovf == 1, "R4 single pulse", n_ovf, 1);
    end

    // R6: flag set and kept through internal reset; R11: service during reset ignored
    check(cause == 1'b1, "R6 cause after overflow", cause, 1);
    rld = '0; sys_n = 1'b0; svc = 1'b1; cyc(); svc = 1'b0; cyc();
    check(cause == 1'b1, "R6/R11 cause kept in reset", cause, 1);
    sys_n = 1'b1; clear_obs();

    // R5 R7: service restarts timing with new reload and clears flag
    run(100);
    service(8);
    check(cause == 1'b0, "R7 service clears cause", cause, 0);
    run(WAIT);
    check(n_ovf == 1 && ovf_at == to_of(8), "R5 service restart", ovf_at, to_of(8));

    // R5: service after overflow does not restart counting
    service(12);
    run(WAIT);
    check(n_ovf == 0, "R5 halted after overflow", n_ovf, 0);

    // R8: disable inside the window
    irst(10);
    run(4);
    pulse_dis();
    run(WAIT);
    check(n_ovf == 0, "R8 disable accepted", n_ovf, 0);

    // R10: internal reset cancels disable
    irst(10);
    run(WAIT);
    check(n_ovf == 1 && ovf_at == to_of(10), "R10 disable cancelled", ovf_at, to_of(10));

    // R9: disable after service ignored
    irst(6);
    run(3);
    service(6);
    run(5);
    pulse_dis();
    run(WAIT);
    check(n_ovf == 1 && ovf_at == to_of(6), "R9 disable after service", ovf_at, to_of(6));

    // R9: disable after end-of-init ignored (einit does not reload)
    irst(9);
    run(2);
    pulse_einit();
    run(2);
    pulse_dis();
    run(WAIT);
    check(n_ovf == 1 && ovf_at == to_of(9), "R9 disable after einit", ovf_at, to_of(9));

    // R10: window reopens after einit-closed run
    irst(9);
    pulse_dis();
    run(WAIT);
    check(n_ovf == 0, "R10 window reopened", n_ovf, 0);

    // R8: disable in the same edge as service is accepted
    irst(4);
    svc = 1'b1; dis = 1'b1; cyc(); svc = 1'b0; dis = 1'b0; clear_obs();
    run(WAIT);
    check(n_ovf == 0, "R8 disable with service", n_ovf, 0);

    // R11: disable during internal reset ignored
    sys_n = 1'b0; rld = 4'd14; dis = 1'b1; cyc(); dis = 1'b0;
    sys_n = 1'b1; clear_obs();
    run(WAIT);
    check(n_ovf == 1 && ovf_at == to_of(14), "R11 disable in reset", ovf_at, to_of(14));

    // R1 R7: power-on reset clears the flag
    check(cause == 1'b1, "R6 cause before por", cause, 1);
    por_n = 1'b0;
    @(negedge clk);
    check(cause == 1'b0 && !ovf, "R1/R7 por clears", cause, 0);
    por_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule